// File: doc/BRIEF.md
# SPI Master Engine with Late Capture

This block is a serial peripheral interface engine that always acts as the bus master. A single start strobe hands it a parallel word. It then lowers chip select and produces sixteen serial clock edges at a programmable rate. On those edges it shifts the word out most-significant bit first and shifts the reply in from the input line. When the transfer ends, it raises chip select and presents the received word with a one-cycle done pulse.

All four combinations of clock polarity and phase are supported. The mode number is defined as polarity times two plus phase. The serial clock half period is an integer count of system clocks, so the duty cycle is exactly 50%.

An optional late-capture setting moves each input sample onto the edge that launches the following output bit. This gives the round trip through the slave a full serial clock period instead of half of one. The last bit has no following launch edge. It is captured at an internal instant one half period after the final clock edge, and the serial clock does not toggle there.

Top module: `spi_host_engine`

## Requirements
- R1: After reset the block is idle: `cs_n`=1, `busy`=0, `done`=0, `mosi`=0. While idle, `sclk` follows `cfg_cpol` one clock later.
- R2: Mode number = 2·`cfg_cpol` + `cfg_cpha`. Each transfer produces exactly 16 `sclk` toggles, starting from and returning to the `cfg_cpol` level.
- R3: With half period H = `cfg_half` (0 is treated as 1), chip select falling, every `sclk` toggle and chip select rising are spaced exactly H system clocks apart.
- R4: `cs_n` falls on the clock edge that accepts `start`. `done` rises 17·H clocks after that edge, lasts exactly one clock, and coincides with `cs_n` rising and `busy` falling.
- R5: `mosi` carries `tx_word` MSB first. With phase 0, bit 7 appears when chip select falls and each later bit appears on the even edges 2..14. With phase 1, the bits appear on the odd edges 1..15.
- R6: With late capture off, `miso` is sampled on the odd edges for phase 0 and on the even edges for phase 1. The first sample becomes bit 7 of `rx_word`.
- R7: With late capture on, `miso` is sampled on the edge that launches the next bit. For phase 0 these are the even edges 2..16. For phase 1 they are the odd edges 3..15, plus a point H clocks after edge 16 at which `sclk` does not toggle. The received word is correct even when the slave's data arrives more than H but less than 2·H clocks after its launch edge.
- R8: `rx_word` updates only at the `done` pulse and then holds until the next `done` pulse.
- R9: A `start` strobe that arrives while `busy` is 1 is ignored. The transmitted data, the timing and the single `done` pulse of the running transfer are unchanged.
- R10: Polarity, phase, late capture and half period are latched when `start` is accepted. Changes during a transfer do not affect it.
- R11: `mosi` returns to 0 at the end of each transfer and stays 0 while idle with phase 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase: 0 = data valid before first edge, 1 = data launched on first edge |
| cfg_late | input | 1 | Late-capture enable |
| cfg_half | input | DIV_W | Serial clock half period in system clocks (0 acts as 1) |
| start | input | 1 | Begin a transfer with `tx_word` |
| tx_word | input | WORD_W | Word to transmit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse: `rx_word` is valid |
| rx_word | output | WORD_W | Last received word |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest condition to reach from the ports is a slave whose reply arrives late. That is the case where late capture matters, and with a prompt slave both capture settings return the same word. The bench models the slave and passes its data bit through a delay line whose length is set per test. A late-capture run with a delay longer than one half period then gets the right word only if the samples really fall on the launch edges, including the internal sample after the last edge in phase 1. Restart strobes and configuration changes are injected at chosen cycles inside a running transfer.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic late;
  } xfer_cfg_t;

  // Half period in system clocks; zero is promoted to one.
  function automatic int unsigned eff_half(input int unsigned h);
    return (h == 0) ? 1 : h;
  endfunction

  // Event k (1..last_edge+1) drives a new output bit.
  function automatic logic launch_at(input int k, input logic cpha, input int last_edge);
    if (cpha) return (k % 2 == 1) && (k <= last_edge - 1);
    else      return (k % 2 == 0) && (k >= 2) && (k <= last_edge - 2);
  endfunction

  // Event k captures the input line.
  function automatic logic sample_at(input int k, input logic cpha, input logic late,
                                     input int last_edge);
    if (!late) begin
      if (cpha) return (k % 2 == 0) && (k >= 2) && (k <= last_edge);
      else      return (k % 2 == 1) && (k <= last_edge - 1);
    end else begin
      if (cpha) return (k % 2 == 1) && (k >= 3) && (k <= last_edge + 1);
      else      return (k % 2 == 0) && (k >= 2) && (k <= last_edge);
    end
  endfunction

endpackage

// File: rtl/spi_host_tick.sv
module spi_host_tick #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_len,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == (half_len - DIV_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + DIV_W'(1);
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half_len));

endmodule

// File: rtl/spi_host_seq.sv
module spi_host_seq
  import spi_host_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_late,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic             tick,
  output logic             busy,
  output logic             cs_n,
  output logic             sclk,
  output logic             done,
  output logic [DIV_W-1:0] half_q,
  output logic             load,
  output logic             launch,
  output logic             sample,
  output logic             finish
);

  localparam int LAST_EDGE = 2 * WORD_W;
  localparam int LAST_EV   = LAST_EDGE + 1;
  localparam int EV_W      = $clog2(LAST_EV + 1);

  logic            busy_q, cs_n_q, sclk_q, done_q;
  logic [EV_W-1:0] ev_q, ev_nxt;
  xfer_cfg_t       cfg_q;

  assign ev_nxt = ev_q + EV_W'(1);
  assign load   = start && !busy_q;
  assign finish = tick && (ev_nxt == EV_W'(LAST_EV));
  assign launch = tick && launch_at(int'(ev_nxt), cfg_q.cpha, LAST_EDGE);
  assign sample = tick && sample_at(int'(ev_nxt), cfg_q.cpha, cfg_q.late, LAST_EDGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
      ev_q   <= '0;
      cfg_q  <= '0;
      half_q <= DIV_W'(1);
    end else begin
      done_q <= finish;
      if (load) begin
        busy_q <= 1'b1;
        cs_n_q <= 1'b0;
        ev_q   <= '0;
        cfg_q  <= '{cpol: cfg_cpol, cpha: cfg_cpha, late: cfg_late};
        half_q <= DIV_W'(eff_half(int'(cfg_half)));
      end else if (tick) begin
        ev_q <= ev_nxt;
        if (finish) begin
          busy_q <= 1'b0;
          cs_n_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       sclk_q <= 1'b0;
    else if (!busy_q)                                 sclk_q <= cfg_cpol;
    else if (tick && (ev_nxt <= EV_W'(LAST_EDGE)))    sclk_q <= ~sclk_q;
  end

  assign busy = busy_q;
  assign cs_n = cs_n_q;
  assign sclk = sclk_q;
  assign done = done_q;

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R3
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(sclk_q));

  // R2
  sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (sclk_q == cfg_q.cpol));

  // R9
  restart_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !finish) |=> (busy_q && $stable(cfg_q) && $stable(half_q)));

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && $past(!busy_q) && $past(rst_n) && $stable(cfg_cpol)) |-> (sclk_q == cfg_cpol));

endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_cpha,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              launch,
  input  logic              sample,
  input  logic              finish,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] tx_sr, rx_sr, rx_nxt;
  logic              mosi_q;
  logic [CNT_W-1:0]  samp_cnt;

  assign rx_nxt = sample ? {rx_sr[WORD_W-2:0], miso} : rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_sr   <= '0;
      mosi_q  <= 1'b0;
      rx_word <= '0;
    end else if (load) begin
      rx_sr <= '0;
      if (load_cpha) begin
        tx_sr <= tx_word;
      end else begin
        mosi_q <= tx_word[WORD_W-1];
        tx_sr  <= {tx_word[WORD_W-2:0], 1'b0};
      end
    end else begin
      if (launch) begin
        mosi_q <= tx_sr[WORD_W-1];
        tx_sr  <= {tx_sr[WORD_W-2:0], 1'b0};
      end
      if (sample) rx_sr <= rx_nxt;
      if (finish) begin
        rx_word <= rx_nxt;
        mosi_q  <= 1'b0;
      end
    end
  end

  assign mosi = mosi_q;

  // Sample tally used only by the check below.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      samp_cnt <= '0;
    else if (load)   samp_cnt <= '0;
    else if (sample) samp_cnt <= samp_cnt + CNT_W'(1);
  end

  // R6 R7
  sample_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> ((int'(samp_cnt) + int'(sample)) == WORD_W));

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(rx_word));

endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine #(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_late,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);

  logic             tick, load, launch, sample, finish;
  logic [DIV_W-1:0] half_q;

  spi_host_tick #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .half_len (half_q),
    .tick     (tick)
  );

  spi_host_seq #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cfg_cpol (cfg_cpol),
    .cfg_cpha (cfg_cpha),
    .cfg_late (cfg_late),
    .cfg_half (cfg_half),
    .tick     (tick),
    .busy     (busy),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .done     (done),
    .half_q   (half_q),
    .load     (load),
    .launch   (launch),
    .sample   (sample),
    .finish   (finish)
  );

  spi_host_shift #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_cpha (cfg_cpha),
    .tx_word   (tx_word),
    .launch    (launch),
    .sample    (sample),
    .finish    (finish),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

  // R4
  done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy && $past(busy)));

endmodule

// File: tb/spi_host_engine_tb.sv
module spi_host_engine_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_late = 1'b0;
  logic [9:0] cfg_half = 10'd1;
  logic       start = 1'b0;
  logic [7:0] tx_word = 8'h00;
  logic       busy, done, sclk, cs_n, mosi;
  logic       miso = 1'b0;
  logic [7:0] rx_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit all_done = 0;

  always #10 clk = ~clk;

  spi_host_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_late(cfg_late), .cfg_half(cfg_half), .start(start), .tx_word(tx_word),
    .busy(busy), .done(done), .rx_word(rx_word), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs one transfer while acting as slave; lag delays the slave's data bit.
  task automatic run_xfer(input logic [1:0] mode, input bit late, input int half,
                          input logic [7:0] tx, input logic [7:0] srx, input int lag,
                          input int poke_cyc, input int flip_cyc, input string rx_req);
    bit cpol, cpha, fin, prev_cs, prev_sclk, fast;
    logic [15:0] pipe;
    logic [7:0]  mcap, rxv;
    int H, cyc, edges, bad_iv, last_ev, cs_fall, done_cyc, done_cnt;
    cpol = mode[1]; cpha = mode[0];
    H = (half == 0) ? 1 : half;
    @(negedge clk);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_late = late; cfg_half = 10'(half);
    tx_word = tx; start = 1'b1;
    @(posedge clk);
    fin = 0; prev_cs = 1; prev_sclk = cpol; fast = 0; pipe = '0; mcap = '0; rxv = '0;
    cyc = 0; edges = 0; bad_iv = 0; last_ev = 0; cs_fall = -1; done_cyc = -1; done_cnt = 0;
    for (int i = 0; i < 20 * H + 10 && !fin; i++) begin
      @(negedge clk);
      if (i == 0) start = 1'b0;
      if (cyc == poke_cyc) begin start = 1'b1; tx_word = ~tx; end
      else if (cyc == poke_cyc + 1) start = 1'b0;
      if (cyc == flip_cyc) begin
        cfg_cpol = ~cpol; cfg_cpha = ~cpha; cfg_late = ~late; cfg_half = 10'(H + 2);
      end
      if (prev_cs && !cs_n) begin
        cs_fall = cyc; last_ev = cyc;
        if (!cpha) fast = srx[7];
      end
      if (!cs_n && sclk != prev_sclk) begin
        edges++;
        if (cyc - last_ev != H) bad_iv++;
        last_ev = cyc;
        if ((!cpha && edges % 2 == 1) || (cpha && edges % 2 == 0)) mcap = {mcap[6:0], mosi};
        if (!cpha && edges % 2 == 0 && edges <= 14) fast = srx[7 - edges / 2];
        if (cpha && edges % 2 == 1) fast = srx[7 - (edges - 1) / 2];
      end
      if (!prev_cs && cs_n && (cyc - last_ev != H)) bad_iv++;
      if (done) begin
        done_cnt++;
        if (done_cyc < 0) begin done_cyc = cyc; rxv = rx_word; end
      end
      if (done_cyc >= 0 && cyc >= done_cyc + 1) fin = 1;
      miso = (lag == 0) ? fast : pipe[lag-1];
      pipe = {pipe[14:0], fast};
      prev_cs = cs_n; prev_sclk = sclk;
      cyc++;
    end
    start = 1'b0;
    chk(cs_fall == 0, "R4", "cs_n fall cycle", cs_fall, 0);
    chk(edges == 16, "R2", "sclk toggles", edges, 16);
    chk(bad_iv == 0, "R3", "mistimed intervals", bad_iv, 0);
    chk(mcap == tx, "R5", "mosi word", mcap, tx);
    chk(rxv == srx, rx_req, "rx_word", rxv, srx);
    chk(done_cyc == 17 * H, "R4", "done cycle", done_cyc, 17 * H);
    chk(done_cnt == 1, "R4", "done pulse count", done_cnt, 1);
    chk(mosi == 1'b0, "R11", "mosi after transfer", mosi, 0);
    if (flip_cyc < 0) chk(sclk == cpol, "R2", "sclk rest level", sclk, cpol);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_late = late; cfg_half = 10'(half);
    miso = 1'b0;
    repeat (3) @(negedge clk);
    chk(rx_word == srx, "R8", "rx_word held", rx_word, srx);
  endtask

  task automatic t_reset();
    chk(cs_n == 1'b1, "R1", "cs_n at reset", cs_n, 1);
    chk(busy == 1'b0, "R1", "busy at reset", busy, 0);
    chk(done == 1'b0, "R1", "done at reset", done, 0);
    chk(mosi == 1'b0, "R1", "mosi at reset", mosi, 0);
    chk(sclk == 1'b0, "R1", "sclk at reset", sclk, 0);
  endtask

  task automatic t_idle_cpol();
    @(negedge clk); cfg_cpol = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1, "R1", "idle sclk follows cpol high", sclk, 1);
    cfg_cpol = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0, "R1", "idle sclk follows cpol low", sclk, 0);
  endtask

  task automatic t_all_modes();
    logic [7:0] txs [4] = '{8'hA5, 8'h3C, 8'h81, 8'h7E};
    logic [7:0] rxs [4] = '{8'h5A, 8'hC9, 8'h0F, 8'hB2};
    for (int m = 0; m < 4; m++) begin
      run_xfer(2'(m), 1'b0, m + 1, txs[m], rxs[m], 0, -5, -5, "R6");
      run_xfer(2'(m), 1'b1, 4 - m, rxs[m], txs[m], 0, -5, -5, "R7");
    end
  endtask

  task automatic t_half_zero();
    run_xfer(2'd0, 1'b0, 0, 8'hC3, 8'h96, 0, -5, -5, "R3");
  endtask

  task automatic t_slow_return();
    run_xfer(2'd0, 1'b1, 3, 8'h55, 8'hD4, 4, -5, -5, "R7");
    run_xfer(2'd1, 1'b1, 3, 8'hE1, 8'h2B, 4, -5, -5, "R7");
    run_xfer(2'd3, 1'b1, 4, 8'h19, 8'hF6, 6, -5, -5, "R7");
  endtask

  task automatic t_busy_start();
    run_xfer(2'd1, 1'b0, 2, 8'h6D, 8'hA0, 0, 7, -5, "R9");
    run_xfer(2'd2, 1'b1, 3, 8'h0B, 8'h74, 0, 30, -5, "R9");
  endtask

  task automatic t_cfg_hold();
    run_xfer(2'd0, 1'b0, 2, 8'h9E, 8'h47, 0, -5, 3, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_idle_cpol();
    t_all_modes();
    t_half_zero();
    t_slow_return();
    t_busy_start();
    t_cfg_hold();
    all_done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!all_done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule